// File: doc/BRIEF.md
# Timer Count-Enable Source Selector

This block produces one-cycle count-enable strobes, in the system clock domain, for two independent 16-bit timer counters. The counters themselves sit elsewhere. Each counter has its own 2-bit source select. The select chooses between four sources: no source, a shared prescaled tick from the system clock, the rising edges of a slow clock that may be asynchronous, or the rising edges of an external event input.

The prescaler divides the system clock by a 5-bit register value plus one. Division therefore runs from 1 to 32. The slow clock and the event input each pass through a two-flop synchronizer and then an edge-detect flop. Each rising edge becomes exactly one enable pulse one system clock wide. Configuration uses plain write strobes. The prescaler value can be read back on a dedicated output. All state moves only on system clock edges, so a stopped system clock stops every strobe and the counters hold.

Top module: `timer_clk_sel`

## Requirements
- R1: While `rst_n` is low, the prescaler value, its down counter, both selects and all synchronizer flops clear to zero. After reset, both `cnt_en` bits stay low until a select is written.
- R2: With the prescaler value D, the prescaled tick repeats every D+1 system clock cycles. It is high in the first cycle after reset and in every cycle in which the down counter is zero.
- R3: A prescaler write changes only the register. The running count completes with the old value, and the new value is first used at the next reload.
- R4: The prescaler value 0 gives a tick in every system clock cycle (division by one).
- R5: With select 2'b10, the counter's `cnt_en` pulses for exactly one cycle per rising edge of `slow_clk`. The pulse appears in the third cycle after the edge is first sampled (two synchronizer flops plus one edge-detect flop). This holds while `slow_clk` stays at each level for at least two system clock cycles.
- R6: With select 2'b11, `cnt_en` pulses for exactly one cycle per rising edge of `ext_evt`, with the same latency as R5.
- R7: With select 2'b00, `cnt_en` for that counter stays low.
- R8: The two counters' selects are independent. Bit i of `sel_wr` writes `sel_wdata` into counter i's select only. Select 2'b01 routes the shared prescaled tick.
- R9: A select change takes effect from the cycle after the write. Switching creates no pulse that the newly selected source would not itself have produced. A select is unchanged in any cycle without its write strobe.
- R10: `presc_rd` returns the prescaler register value from the cycle after a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| presc_wr | input | 1 | Write strobe for the prescaler register |
| presc_wdata | input | 5 | Prescaler divide value minus one |
| presc_rd | output | 5 | Current prescaler register value |
| sel_wr | input | 2 | Per-counter write strobe for the source select |
| sel_wdata | input | 2 | Select code: 00 none, 01 prescaled, 10 slow clock, 11 event |
| slow_clk | input | 1 | Slow clock, possibly asynchronous, at most a quarter of clk |
| ext_evt | input | 1 | External event input, possibly asynchronous |
| cnt_en | output | 2 | One-cycle count-enable strobe per counter |

## Verification
The bench drives random prescaler values and random select changes against a slow clock and an event input. The slow clock and the event input toggle with random hold times of at least two cycles, so every pairing of sources on the two counters occurs. Random hold lengths tell a correct one-pulse-per-edge detector apart from one that pulses on both edges or stretches its pulse. Random prescaler writes arriving mid-count separate reload-time loading from immediate loading. Directed runs pin down division by one, a write during a long count, and the two counters on different sources at the same time, which exposes any crossing between the per-counter selects.

// File: rtl/tclk_pkg.sv
// Package: shared types for the timer count-enable source selector.
// Assumes: two select bits per counter, one code per source.
package tclk_pkg;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'b00,
        SRC_PRESC = 2'b01,
        SRC_SLOW  = 2'b10,
        SRC_EVENT = 2'b11
    } src_sel_e;

    localparam int SEL_W   = 2;
    localparam int NUM_SRC = 1 << SEL_W;

endpackage

// File: rtl/tclk_prescaler.sv
// Module: tclk_prescaler
// Divides the system clock by (div + 1) using a down counter that reloads
// from a software-written register. The tick is high while the counter is
// zero. A register write lands only in the register; the counter picks it
// up at its next reload.
// Assumes: synchronous active-low reset, single clock domain.
module tclk_prescaler #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wr_data,
    output logic [DIV_W-1:0] div_q,
    output logic [DIV_W-1:0] cnt_q,
    output logic             tick
);

    localparam logic [DIV_W-1:0] ZERO = '0;
    localparam logic [DIV_W-1:0] ONE  = {{(DIV_W-1){1'b0}}, 1'b1};

    logic reload;

    // Reload point: counter has run down to zero
    always_comb begin
        reload = (cnt_q == ZERO);
        tick   = reload;
    end

    // Divide register: loads on a write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= ZERO;
        end else if (wr_en) begin
            div_q <= wr_data;
        end
    end

    // Down counter: reloads from the register at zero, else counts down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ZERO;
        end else if (reload) begin
            cnt_q <= div_q;
        end else begin
            cnt_q <= cnt_q - ONE;
        end
    end

endmodule

// File: rtl/tclk_edge_sync.sv
// Module: tclk_edge_sync
// Brings an asynchronous level into the system clock domain through
// SYNC_STAGES flops, then adds one flop and emits a one-cycle pulse on each
// rising edge of the synchronized level.
// Assumes: the input holds each level for at least two system clock cycles
// (input at no more than a quarter of the system clock); SYNC_STAGES >= 2.
module tclk_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);

    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN:0] chain;

    // Chain input: raw asynchronous level
    always_comb chain[0] = async_in;

    for (genvar g = 1; g <= CHAIN; g++) begin : g_stage
        // One synchronizer or edge-detect stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain[g] <= 1'b0;
            end else begin
                chain[g] <= chain[g-1];
            end
        end
    end

    // Rising edge: synchronized level high, delayed copy still low
    always_comb rise_pulse = chain[CHAIN-1] & ~chain[CHAIN];

endmodule

// File: rtl/tclk_src_mux.sv
// Module: tclk_src_mux
// Holds the source select of one counter and routes the chosen pulse source
// to that counter's count enable. Source 0 is tied low.
// Assumes: every source is already a one-cycle pulse in the clk domain, so
// switching the select cannot produce a pulse by itself.
module tclk_src_mux
    import tclk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_wr,
    input  logic [SEL_W-1:0]   sel_wdata,
    input  logic [NUM_SRC-1:0] src_pulse,
    output logic [SEL_W-1:0]   sel_q,
    output logic               cnt_en
);

    src_sel_e sel_e;

    // Select register: resets to no source, loads on its write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= SRC_NONE;
        end else if (sel_wr) begin
            sel_q <= sel_wdata;
        end
    end

    // Route the chosen source to the count enable
    always_comb begin
        sel_e = src_sel_e'(sel_q);
        unique case (sel_e)
            SRC_NONE:  cnt_en = 1'b0;
            SRC_PRESC: cnt_en = src_pulse[SRC_PRESC];
            SRC_SLOW:  cnt_en = src_pulse[SRC_SLOW];
            SRC_EVENT: cnt_en = src_pulse[SRC_EVENT];
            default:   cnt_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/timer_clk_sel.sv
// Module: timer_clk_sel (top)
// Count-enable generator for NUM_CNT timer counters. One shared prescaler
// tick, a synchronized slow-clock edge and a synchronized event edge feed one
// source mux per counter.
// Assumes: slow_clk and ext_evt hold each level for at least two clk cycles;
// all outputs are in the clk domain and freeze when clk stops.
module timer_clk_sel
    import tclk_pkg::*;
#(
    parameter int NUM_CNT     = 2,
    parameter int DIV_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               presc_wr,
    input  logic [DIV_W-1:0]   presc_wdata,
    output logic [DIV_W-1:0]   presc_rd,
    input  logic [NUM_CNT-1:0] sel_wr,
    input  logic [SEL_W-1:0]   sel_wdata,
    input  logic               slow_clk,
    input  logic               ext_evt,
    output logic [NUM_CNT-1:0] cnt_en
);

    logic [DIV_W-1:0]         presc_div;
    logic [DIV_W-1:0]         presc_cnt;
    logic                     presc_tick;
    logic                     slow_pulse;
    logic                     evt_pulse;
    logic [NUM_SRC-1:0]       src_pulse;
    logic [NUM_CNT*SEL_W-1:0] sel_all;

    tclk_prescaler #(
        .DIV_W (DIV_W)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (presc_wr),
        .wr_data (presc_wdata),
        .div_q   (presc_div),
        .cnt_q   (presc_cnt),
        .tick    (presc_tick)
    );

    tclk_edge_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_slow_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (slow_clk),
        .rise_pulse (slow_pulse)
    );

    tclk_edge_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_evt_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (ext_evt),
        .rise_pulse (evt_pulse)
    );

    // Gather the pulse sources in select-code order
    always_comb begin
        src_pulse            = '0;
        src_pulse[SRC_PRESC] = presc_tick;
        src_pulse[SRC_SLOW]  = slow_pulse;
        src_pulse[SRC_EVENT] = evt_pulse;
        presc_rd             = presc_div;
    end

    for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
        tclk_src_mux u_mux (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel_wr    (sel_wr[c]),
            .sel_wdata (sel_wdata),
            .src_pulse (src_pulse),
            .sel_q     (sel_all[c*SEL_W +: SEL_W]),
            .cnt_en    (cnt_en[c])
        );
    end

endmodule

// File: rtl/timer_clk_sel_chk.sv
// Module: timer_clk_sel_chk
// Assertion checker bound to timer_clk_sel. It watches the prescaler reload,
// the pulse width of the edge detectors and the per-counter select behaviour.
module timer_clk_sel_chk
    import tclk_pkg::*;
#(
    parameter int NUM_CNT = 2,
    parameter int DIV_W   = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [DIV_W-1:0]         presc_div,
    input logic [DIV_W-1:0]         presc_cnt,
    input logic                     presc_tick,
    input logic                     slow_pulse,
    input logic                     evt_pulse,
    input logic [NUM_CNT*SEL_W-1:0] sel_all,
    input logic [NUM_CNT-1:0]       sel_wr,
    input logic [NUM_CNT-1:0]       cnt_en
);

    // R2 and R3: after a tick the counter holds the register value of that cycle
    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        presc_tick |=> presc_cnt == $past(presc_div));

    // R2: a non-zero divide value never gives two ticks in a row
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (presc_tick && presc_div != '0) |=> !presc_tick);

    // R5: a slow-clock edge pulse lasts one cycle
    p_slow_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        slow_pulse |=> !slow_pulse);

    // R6: an event edge pulse lasts one cycle
    p_evt_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse |=> !evt_pulse);

    for (genvar c = 0; c < NUM_CNT; c++) begin : g_chk
        // R7: the no-source code keeps the strobe low
        p_none_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_all[c*SEL_W +: SEL_W] == SRC_NONE) |-> !cnt_en[c]);

        // R9: a select moves only under its own write strobe
        p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !sel_wr[c] |=> $stable(sel_all[c*SEL_W +: SEL_W]));
    end

endmodule

bind timer_clk_sel timer_clk_sel_chk #(
    .NUM_CNT (NUM_CNT),
    .DIV_W   (DIV_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .presc_div  (presc_div),
    .presc_cnt  (presc_cnt),
    .presc_tick (presc_tick),
    .slow_pulse (slow_pulse),
    .evt_pulse  (evt_pulse),
    .sel_all    (sel_all),
    .sel_wr     (sel_wr),
    .cnt_en     (cnt_en)
);

// File: tb/timer_clk_sel_tb.sv
// Bench for timer_clk_sel: constrained random traffic with a fixed seed and
// directed corner cases, compared every cycle against a reference model
// written from the requirements.
module timer_clk_sel_tb;

    localparam int NC = 2;
    localparam int DW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          presc_wr = 1'b0;
    logic [DW-1:0] presc_wdata = '0;
    logic [DW-1:0] presc_rd;
    logic [NC-1:0] sel_wr = '0;
    logic [1:0]    sel_wdata = '0;
    logic          slow_clk = 1'b0;
    logic          ext_evt = 1'b0;
    logic [NC-1:0] cnt_en;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;
    bit auto_in = 1'b0;
    int slow_hold = 3;
    int evt_hold = 2;
    string phase_tag = "";

    // Reference model state
    logic [DW-1:0] m_div, m_cnt;
    logic [1:0]    m_sel [NC];
    logic [2:0]    m_slow, m_evt;

    always #4 clk = ~clk;

    timer_clk_sel u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .presc_wr    (presc_wr),
        .presc_wdata (presc_wdata),
        .presc_rd    (presc_rd),
        .sel_wr      (sel_wr),
        .sel_wdata   (sel_wdata),
        .slow_clk    (slow_clk),
        .ext_evt     (ext_evt),
        .cnt_en      (cnt_en)
    );

    // Model of R1..R10 advanced on each rising clock edge
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            m_div <= '0; m_cnt <= '0; m_slow <= '0; m_evt <= '0;
            for (int i = 0; i < NC; i++) m_sel[i] <= 2'b00;
        end else begin
            m_cnt  <= (m_cnt == '0) ? m_div : m_cnt - 1'b1;
            if (presc_wr) m_div <= presc_wdata;
            m_slow <= {m_slow[1:0], slow_clk};
            m_evt  <= {m_evt[1:0], ext_evt};
            for (int i = 0; i < NC; i++) if (sel_wr[i]) m_sel[i] <= sel_wdata;
        end
    end

    function automatic logic exp_en(input logic [1:0] s);
        case (s)
            2'b01:   return m_cnt == '0;
            2'b10:   return m_slow[1] & ~m_slow[2];
            2'b11:   return m_evt[1] & ~m_evt[2];
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag_of(input logic [1:0] s);
        if (phase_tag != "") return phase_tag;
        case (s)
            2'b01:   return "R2";
            2'b10:   return "R5";
            2'b11:   return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cycles);
        end
    endtask

    // One cycle: check at the falling edge, then clear strobes and move inputs
    task automatic step();
        @(negedge clk);
        for (int i = 0; i < NC; i++)
            check(tag_of(m_sel[i]), 32'(cnt_en[i]), 32'(exp_en(m_sel[i])));
        check("R10", 32'(presc_rd), 32'(m_div));
        presc_wr = 1'b0;
        sel_wr   = '0;
        if (auto_in) begin
            slow_hold--;
            if (slow_hold == 0) begin
                slow_clk  = ~slow_clk;
                slow_hold = 2 + int'($urandom % 6);
            end
            evt_hold--;
            if (evt_hold == 0) begin
                ext_evt  = ~ext_evt;
                evt_hold = 2 + int'($urandom % 5);
            end
        end
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic wr_presc(input logic [DW-1:0] v);
        presc_wr = 1'b1; presc_wdata = v;
    endtask

    task automatic wr_sel(input logic [NC-1:0] m, input logic [1:0] v);
        sel_wr = m; sel_wdata = v;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        wait (cycles > 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int gap;
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check("R1", 32'(cnt_en), 32'd0);
        check("R1", 32'(presc_rd), 32'd0);
        rst_n = 1'b1;
        phase_tag = "R1";
        run(6);
        phase_tag = "";

        // R4: divide value 0 ticks every cycle, counter 0 on the prescaler
        phase_tag = "R4";
        wr_sel(2'b01, 2'b01);
        step();
        for (int k = 0; k < 8; k++) begin
            step();
            check("R4", 32'(cnt_en[0]), 32'd1);
        end
        phase_tag = "";

        // R2: divide by 4, measure the spacing between strobes
        wr_presc(5'd3);
        run(12);
        gap = 0;
        while (cnt_en[0] !== 1'b1 && gap < 40) begin step(); gap++; end
        gap = 0;
        do begin step(); gap++; end while (cnt_en[0] !== 1'b1 && gap < 40);
        check("R2", 32'(gap), 32'd4);

        // R3: a long divide written mid-count takes effect at the next reload
        phase_tag = "R3";
        step();
        wr_presc(5'd31);
        run(80);
        wr_presc(5'd0);
        run(40);
        phase_tag = "";

        // R8: counters on different sources at once
        phase_tag = "R8";
        auto_in = 1'b1;
        wr_presc(5'd2);
        step();
        wr_sel(2'b10, 2'b10);
        run(60);
        wr_sel(2'b01, 2'b11);
        step();
        wr_sel(2'b10, 2'b01);
        run(60);
        phase_tag = "";

        // R9: switch selects while pulses are in flight
        phase_tag = "R9";
        for (int k = 0; k < 40; k++) begin
            wr_sel(NC'($urandom % 4), 2'($urandom));
            step();
        end
        phase_tag = "";

        // Random mix of writes and input activity
        for (int k = 0; k < 6000; k++) begin
            if ($urandom % 16 == 0) wr_presc(DW'($urandom));
            if ($urandom % 10 == 0) wr_sel(NC'($urandom % 4), 2'($urandom));
            step();
        end

        // R7: both counters back to no source
        auto_in = 1'b1;
        wr_sel(2'b11, 2'b00);
        step();
        for (int k = 0; k < 30; k++) begin
            step();
            check("R7", 32'(cnt_en), 32'd0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule